// File: doc/BRIEF.md
# Conversion Sequencer for a Sampling Converter Core

This block sits between a small configuration register and an analog-to-digital converter core. It decides when the core gets power, when the core receives its start pulse, and when the core's result is copied into the output register. Software selects continuous operation or one-shot operation with a mode bit. One flag bit serves two purposes. Writing it as 1 requests a conversion. The block clears it to 0 when a one-shot conversion has finished, so the same bit reports that data is ready.

In continuous operation the core stays powered and restarts as soon as each result is captured. In one-shot operation the core stays unpowered until the flag is written as 1. The core then runs exactly one conversion and powers down again. When the mode changes from continuous to one-shot, the conversion in flight is allowed to complete before power is removed. A synchronous general-call reset input returns the whole block to its power-up state, in the same way as the asynchronous reset.

Top module: `conv_sequencer`

## Requirements
- R1: After the asynchronous reset, configuration readback is 8'h80 and the output register is 0. Power-enable is low during the first cycle after release. Readback layout: bit 7 is the start/ready flag, bits 6:5 are reserved, bit 4 is the mode (1 = one-shot, 0 = continuous) and bits 3:0 are the core settings.
- R2: Power-enable is high in the cycle before every start pulse. A start pulse lasts exactly one cycle.
- R3: In continuous mode, a done that arrives while a conversion is in progress loads the result into the output register. The next start pulse follows in the very next cycle, and power-enable stays high.
- R4: In one-shot mode the block stays powered down until a write sets the flag. Power-enable rises in the cycle after that write, and the start pulse follows one cycle later. Exactly one conversion runs.
- R5: When a one-shot conversion finishes, the result is stored, the flag reads 0 and power-enable is low from the next cycle on.
- R6: While power-enable is high, writes to the start/ready flag have no effect, whether they write 1 or 0. They never cause an extra conversion.
- R7: A switch from continuous to one-shot mode made during a conversion lets that conversion finish and store its result. The flag is then cleared, power is removed and no further start pulse follows.
- R8: A write that selects continuous mode while the block is idle raises power-enable in the next cycle, and the start pulse follows one cycle after that.
- R9: Settings bits 3:0 reach the settings output and readback in the cycle after a write, even during a conversion. Such a write neither restarts nor ends the conversion. Reserved bits 6:5 always read 0.
- R10: The output register changes only when done arrives during a conversion. A done pulse at any other time is ignored.
- R11: A general-call reset pulse returns the block to its reset state in the next cycle: readback 8'h80, output register 0, settings 0 and power-enable low. Continuous operation then resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gc_rst | input | 1 | Synchronous general-call reset pulse |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | SET_W+4 | Configuration write data |
| core_done | input | 1 | Conversion finished flag from the core |
| core_result | input | DATA_W | Result from the core |
| core_pwr | output | 1 | Core power-enable |
| core_start | output | 1 | Single-cycle conversion start |
| core_setting | output | SET_W | Settings bits sent to the core |
| result_q | output | DATA_W | Output register |
| cfg_rd | output | SET_W+4 | Configuration readback |

## Verification
A sequencer stuck in the wrong state shows up at the ports within one or two cycles. A missing start or power pulse, a start with no power-enable in the cycle before it, or power held on after a one-shot finish can each be observed directly on the core-facing outputs. A wrong flag or mode value appears on readback in the cycle after the write or the finishing done. A latch of the result at the wrong time changes the output register when no conversion was running. The directed scenarios sample at these exact cycles, and they count start pulses over idle windows to detect conversions that should not have happened.

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
  parameter int DATA_W = 16,
  parameter int SET_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gc_rst,
  input  logic              cfg_wr,
  input  logic [SET_W+3:0]  cfg_wdata,
  input  logic              core_done,
  input  logic [DATA_W-1:0] core_result,
  output logic              core_pwr,
  output logic              core_start,
  output logic [SET_W-1:0]  core_setting,
  output logic [DATA_W-1:0] result_q,
  output logic [SET_W+3:0]  cfg_rd
);
  localparam int CFG_W  = SET_W + 4;
  localparam int MODE_B = SET_W;
  localparam int SRDY_B = CFG_W - 1;
  localparam int RSV_W  = 2;

  typedef enum logic [1:0] {S_IDLE, S_WAKE, S_START, S_WAIT} st_t;

  st_t st, st_nx;
  logic [SET_W-1:0] set_q, set_nx;
  logic mode_q, mode_nx, srdy_q, srdy_nx;
  logic idle, in_conv, fin, go;

  assign idle    = (st == S_IDLE);
  assign in_conv = (st == S_WAIT);
  assign fin     = in_conv && core_done;

  assign set_nx  = cfg_wr ? cfg_wdata[SET_W-1:0] : set_q;
  assign mode_nx = cfg_wr ? cfg_wdata[MODE_B] : mode_q;
  assign srdy_nx = (cfg_wr && idle)  ? cfg_wdata[SRDY_B] :
                   (fin && mode_nx)  ? 1'b0 : srdy_q;
  assign go      = !mode_nx || srdy_nx;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:  if (go) st_nx = S_WAKE;
      S_WAKE:  st_nx = S_START;
      S_START: st_nx = S_WAIT;
      S_WAIT:  if (core_done) st_nx = mode_nx ? S_IDLE : S_START;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      set_q    <= '0;
      mode_q   <= 1'b0;
      srdy_q   <= 1'b1;
      result_q <= '0;
    end else if (gc_rst) begin
      st       <= S_IDLE;
      set_q    <= '0;
      mode_q   <= 1'b0;
      srdy_q   <= 1'b1;
      result_q <= '0;
    end else begin
      st     <= st_nx;
      set_q  <= set_nx;
      mode_q <= mode_nx;
      srdy_q <= srdy_nx;
      if (fin) result_q <= core_result;
    end
  end

  assign core_pwr     = !idle;
  assign core_start   = (st == S_START);
  assign core_setting = set_q;
  assign cfg_rd       = {srdy_q, {RSV_W{1'b0}}, mode_q, set_q};
endmodule

// File: rtl/conv_sequencer_chk.sv
module conv_sequencer_chk #(
  parameter int DATA_W = 16,
  parameter int SET_W  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              gc_rst,
  input logic              cfg_wr,
  input logic [SET_W+3:0]  cfg_wdata,
  input logic              core_done,
  input logic              core_pwr,
  input logic              core_start,
  input logic [DATA_W-1:0] result_q,
  input logic [SET_W+3:0]  cfg_rd,
  input logic              idle,
  input logic              in_conv
);
  localparam int CFG_W  = SET_W + 4;
  localparam int MODE_B = SET_W;
  localparam int SRDY_B = CFG_W - 1;
  localparam logic [CFG_W-1:0] CFG_DEF = {1'b1, {(CFG_W-1){1'b0}}};

  assert_pwr_before_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |-> $past(core_pwr));

  assert_start_one_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    core_start |=> !core_start);

  assert_cont_restart_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && core_done && !gc_rst && !cfg_rd[MODE_B] && !(cfg_wr && cfg_wdata[MODE_B]))
    |=> (core_start && core_pwr));

  assert_single_powerdown_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_conv && core_done && !gc_rst && cfg_rd[MODE_B] && !(cfg_wr && !cfg_wdata[MODE_B]))
    |=> (!core_pwr && !cfg_rd[SRDY_B]));

  assert_flag_ignored_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !gc_rst && !(in_conv && core_done)) |=> $stable(cfg_rd[SRDY_B]));

  assert_result_only_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_conv && core_done) && !gc_rst) |=> $stable(result_q));

  assert_gc_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
    gc_rst |=> (cfg_rd == CFG_DEF && !core_pwr && result_q == '0));
endmodule

bind conv_sequencer conv_sequencer_chk #(.DATA_W(DATA_W), .SET_W(SET_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .gc_rst(gc_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
  .core_done(core_done), .core_pwr(core_pwr), .core_start(core_start),
  .result_q(result_q), .cfg_rd(cfg_rd), .idle(idle), .in_conv(in_conv)
);

// File: tb/test_conv_sequencer.sv
module test_conv_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 4;
  localparam int WD_CYCLES = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic gc_rst = 1'b0;
  logic cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic core_done;
  logic [15:0] core_result;
  logic core_pwr, core_start;
  logic [3:0] core_setting;
  logic [15:0] result_q;
  logic [7:0] cfg_rd;

  int n_checks = 0;
  int n_fail = 0;

  logic [3:0] cnt;
  logic [15:0] pend;
  int n_starts;
  logic stray = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_sequencer i_conv_sequencer (
    .clk(clk), .rst_n(rst_n), .gc_rst(gc_rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .core_done(core_done), .core_result(core_result), .core_pwr(core_pwr),
    .core_start(core_start), .core_setting(core_setting), .result_q(result_q), .cfg_rd(cfg_rd)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      cnt <= '0; pend <= '0; n_starts <= 0;
    end else if (core_start) begin
      cnt <= 4'(LAT);
      pend <= 16'hA000 + 16'(n_starts);
      n_starts <= n_starts + 1;
    end else if (cnt != 0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign core_done   = (cnt == 4'd1) || stray;
  assign core_result = stray ? 16'hDEAD : pend;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr = 1'b1; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_done(output logic [15:0] res);
    bit seen = 0;
    res = '0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (core_done) begin seen = 1; res = core_result; end
    end
    chk(seen, "R3 done timeout", 32'(seen), 1);
  endtask

  task automatic wait_start();
    bit seen = 0;
    for (int i = 0; i < 50 && !seen; i++) begin
      @(negedge clk);
      if (core_start) seen = 1;
    end
    chk(seen, "R2 start timeout", 32'(seen), 1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!core_pwr, "R1 pwr after reset", 32'(core_pwr), 0);
    chk(cfg_rd == 8'h80, "R1 cfg after reset", 32'(cfg_rd), 32'h80);
    chk(result_q == 0, "R1 result after reset", 32'(result_q), 0);
    @(negedge clk);
    chk(core_pwr && !core_start, "R2 wake cycle", {core_pwr, core_start}, 32'b10);
    @(negedge clk);
    chk(core_pwr && core_start, "R2 start with pwr", {core_pwr, core_start}, 32'b11);
    @(negedge clk);
    chk(!core_start, "R2 start single cycle", 32'(core_start), 0);
  endtask

  task automatic t_cont();
    logic [15:0] exp;
    for (int k = 0; k < 2; k++) begin
      wait_done(exp);
      @(negedge clk);
      chk(core_start && core_pwr, "R3 restart after done", {core_pwr, core_start}, 32'b11);
      chk(result_q == exp, "R3 result latched", 32'(result_q), 32'(exp));
    end
  endtask

  task automatic t_cont_to_single();
    logic [15:0] exp;
    int s0;
    wait_start();
    @(negedge clk);
    wr(8'h10);
    chk(cfg_rd == 8'h90, "R6 flag kept while busy", 32'(cfg_rd), 32'h90);
    s0 = n_starts;
    wait_done(exp);
    @(negedge clk);
    chk(!core_pwr, "R7 power down after switch", 32'(core_pwr), 0);
    chk(cfg_rd == 8'h10, "R7 flag cleared", 32'(cfg_rd), 32'h10);
    chk(result_q == exp, "R7 running result stored", 32'(result_q), 32'(exp));
    repeat (10) @(negedge clk);
    chk(n_starts == s0 && !core_pwr, "R7 no further start", 32'(n_starts), 32'(s0));
  endtask

  task automatic t_idle_ignore();
    logic [15:0] keep;
    keep = result_q;
    stray = 1'b1;
    @(negedge clk);
    stray = 1'b0;
    chk(result_q == keep, "R10 stray done ignored", 32'(result_q), 32'(keep));
    chk(!core_pwr, "R10 stray done no power", 32'(core_pwr), 0);
    wr(8'h70);
    chk(cfg_rd == 8'h10, "R9 reserved bits read 0", 32'(cfg_rd), 32'h10);
    repeat (3) @(negedge clk);
    chk(!core_pwr, "R4 idle without flag", 32'(core_pwr), 0);
  endtask

  task automatic t_single_shot();
    logic [15:0] exp;
    int s0;
    s0 = n_starts;
    wr(8'h90);
    chk(core_pwr && !core_start, "R4 power before start", {core_pwr, core_start}, 32'b10);
    @(negedge clk);
    chk(core_start, "R4 start pulse", 32'(core_start), 1);
    wait_done(exp);
    @(negedge clk);
    chk(!core_pwr, "R5 power down", 32'(core_pwr), 0);
    chk(cfg_rd == 8'h10, "R5 flag reads 0", 32'(cfg_rd), 32'h10);
    chk(result_q == exp, "R5 result stored", 32'(result_q), 32'(exp));
    repeat (10) @(negedge clk);
    chk(n_starts == s0 + 1, "R4 exactly one conversion", 32'(n_starts), 32'(s0 + 1));
  endtask

  task automatic t_busy_write();
    logic [15:0] exp;
    int s0;
    s0 = n_starts;
    wr(8'h90);
    @(negedge clk);
    @(negedge clk);
    wr(8'h10);
    chk(cfg_rd == 8'h90, "R6 write 0 ignored busy", 32'(cfg_rd), 32'h90);
    wr(8'h90);
    wait_done(exp);
    @(negedge clk);
    chk(cfg_rd == 8'h10 && !core_pwr, "R6 ends normally", 32'(cfg_rd), 32'h10);
    repeat (8) @(negedge clk);
    chk(n_starts == s0 + 1, "R6 no extra conversion", 32'(n_starts), 32'(s0 + 1));
  endtask

  task automatic t_settings();
    logic [15:0] exp;
    int s0;
    s0 = n_starts;
    wr(8'h90);
    @(negedge clk);
    @(negedge clk);
    wr(8'h13);
    chk(core_setting == 4'h3, "R9 settings applied", 32'(core_setting), 3);
    chk(cfg_rd == 8'h93, "R9 readback during conversion", 32'(cfg_rd), 32'h93);
    chk(core_pwr && !core_start, "R9 no restart", {core_pwr, core_start}, 32'b10);
    wait_done(exp);
    @(negedge clk);
    repeat (5) @(negedge clk);
    chk(n_starts == s0 + 1 && !core_pwr, "R9 conversion completes once", 32'(n_starts), 32'(s0 + 1));
  endtask

  task automatic t_to_cont();
    wr(8'h05);
    chk(core_pwr && !core_start, "R8 power next cycle", {core_pwr, core_start}, 32'b10);
    chk(cfg_rd == 8'h05, "R8 readback", 32'(cfg_rd), 32'h05);
    @(negedge clk);
    chk(core_start, "R8 start follows", 32'(core_start), 1);
  endtask

  task automatic t_gc();
    wait_start();
    @(negedge clk);
    gc_rst = 1'b1;
    @(negedge clk);
    gc_rst = 1'b0;
    chk(!core_pwr, "R11 power low", 32'(core_pwr), 0);
    chk(cfg_rd == 8'h80, "R11 cfg default", 32'(cfg_rd), 32'h80);
    chk(result_q == 0 && core_setting == 0, "R11 result and settings cleared",
        {result_q, 12'h0, core_setting}, 0);
    @(negedge clk);
    chk(core_pwr, "R11 continuous resumes", 32'(core_pwr), 1);
  endtask

  initial begin
    t_reset();
    t_cont();
    t_cont_to_single();
    t_idle_ignore();
    t_single_shot();
    t_busy_write();
    t_settings();
    t_to_cont();
    t_gc();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog (all requirements) actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule